// File: doc/BRIEF.md
# Dual-Channel UART Sleep Controller

This block runs on an always-on clock and decides when a two-channel UART may stop its baud oscillator. It watches every channel's interrupt, divisor, sleep-enable and modem-delta status, along with the receive line levels. When all of them permit it on every channel, it drops the oscillator enable. If the power-save strap is high, it also raises a bus-isolate enable so that a floating or toggling host bus cannot disturb the sleeping device.

A wake event restarts the oscillator. Depending on the state, the wake events are a start-bit edge, a modem-line change or a host write to a transmitter. The datapath clock is reported valid only after a start-up window measured in always-on cycles. Once interrupts are serviced, modem changes have been acknowledged by a modem-status read, and the lines are idle again, the block goes back to sleep with no host command. Clearing any channel's sleep-enable keeps the device awake.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: While reset is held, `state_o` is AWAKE, `osc_en_o` = 1, `clk_valid_o` = 1 and `bus_iso_o` = 0. The state encoding is AWAKE=0, SLEEP=1, PSAVE=2, WAKING=3.
- R2: From AWAKE, the block leaves AWAKE on the clock edge that samples every entry condition true on all channels. It goes to SLEEP, or to PSAVE when the synchronized strap is high. In SLEEP, `osc_en_o` = 0, `clk_valid_o` = 0 and `bus_iso_o` = 0.
- R3: No channel with `irq_pend_i` high lets the block leave AWAKE.
- R4: Entry is also blocked while any channel has `div_nz_i` low, `slp_en_i` low, a non-zero 4-bit delta field (channel c in bits 4c+3..4c), or a synchronized receive level that is low.
- R5: In SLEEP, a host write strobe `thr_wr_i` moves the block to WAKING on the sampling edge. Receive falling edges and modem-line changes on `modem_i` (channel c in bits 4c+3..4c) also move it to WAKING. Those inputs pass through two synchronizer flops, so a change driven before edge k takes effect at edge k+2.
- R6: WAKING lasts exactly STARTUP_CYC cycles with `osc_en_o` = 1 and `clk_valid_o` = 0, then the block returns to AWAKE.
- R7: After a wake, the block re-enters sleep by itself as soon as all entry conditions hold again.
- R8: A modem-line change on channel c blocks entry until the cycle after `msr_rd_i[c]` is seen. A read of another channel does not release it.
- R9: Clearing any `slp_en_i` bit while in SLEEP or PSAVE moves the block to WAKING. It then stays AWAKE while the bit is clear.
- R10: In PSAVE, `bus_iso_o` = 1 and `osc_en_o` = 0. From SLEEP, a high synchronized strap moves the block to PSAVE.
- R11: In PSAVE, `thr_wr_i` has no effect, while receive falling edges and modem changes still wake the block. After such a wake, re-entry goes straight to PSAVE.
- R12: With a low synchronized strap, PSAVE returns to SLEEP and releases `bus_iso_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on control clock |
| rst_aon_n | input | 1 | Asynchronous active-low reset |
| irq_pend_i | input | NCH | Interrupt pending, one bit per channel |
| div_nz_i | input | NCH | Baud divisor is non-zero, per channel |
| slp_en_i | input | NCH | Sleep enable register bit, per channel |
| msr_delta_i | input | NCH*4 | Modem-status delta bits, 4 per channel |
| rx_i | input | NCH | Asynchronous receive line levels |
| modem_i | input | NCH*4 | Asynchronous modem lines, 4 per channel |
| thr_wr_i | input | NCH | Host write into a transmitter, per channel |
| msr_rd_i | input | NCH | Host read of modem status, per channel |
| psave_strap_i | input | 1 | Power-save strap, asynchronous level |
| osc_en_o | output | 1 | Baud oscillator enable |
| bus_iso_o | output | 1 | Host bus isolation enable |
| clk_valid_o | output | 1 | Datapath clock is stable |
| state_o | output | 2 | Current state code |

## Verification
The bench builds the block with two channels and a start-up window of 5 cycles. This keeps each wake and re-sleep round trip to about ten cycles, so one run can cover every wake source from both SLEEP and PSAVE, and the cross-channel modem-read release. The same short window lets the bench check the exact cycle at which `clk_valid_o` returns and the immediate re-entry that follows.

// File: rtl/uart_slp_pkg.sv
package uart_slp_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_PSAVE  = 2'd2,
    ST_WAKING = 2'd3
  } slp_state_e;

endpackage

// File: rtl/slp_sync.sv
// Two-stage level synchronizer with a selectable reset level.
module slp_sync #(
  parameter int W       = 1,
  parameter bit RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_BIT}};
      sync_q <= {W{RST_BIT}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/slp_wake_det.sv
// Edge detection on synchronized receive and modem lines.
module slp_wake_det #(
  parameter int NCH  = 2,
  parameter int NMDM = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      rx_s_i,
  input  logic [NCH*NMDM-1:0] mdm_s_i,
  output logic                rx_fall_o,
  output logic [NCH-1:0]      mdm_chg_o
);

  logic [NCH-1:0]      rx_prev_q;
  logic [NCH*NMDM-1:0] mdm_prev_q;
  logic [NCH-1:0]      rx_fall_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev_q  <= {NCH{1'b1}};
      mdm_prev_q <= '0;
    end else begin
      rx_prev_q  <= rx_s_i;
      mdm_prev_q <= mdm_s_i;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign rx_fall_vec[c] = rx_prev_q[c] & ~rx_s_i[c];
    assign mdm_chg_o[c]   = |(mdm_prev_q[c*NMDM +: NMDM] ^ mdm_s_i[c*NMDM +: NMDM]);
  end

  assign rx_fall_o = |rx_fall_vec;

  // R5
  rx_fall_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fall_o |=> ~&rx_prev_q);

endmodule

// File: rtl/slp_entry_qual.sv
// Combines the per-channel sleep-entry conditions and tracks unacknowledged
// modem changes until the matching status read.
module slp_entry_qual #(
  parameter int NCH  = 2,
  parameter int NMDM = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      irq_i,
  input  logic [NCH-1:0]      dnz_i,
  input  logic [NCH-1:0]      en_i,
  input  logic [NCH*NMDM-1:0] delta_i,
  input  logic [NCH-1:0]      rx_s_i,
  input  logic [NCH-1:0]      mdm_chg_i,
  input  logic [NCH-1:0]      msr_rd_i,
  input  logic                wake_now_i,
  output logic                entry_ok_o,
  output logic                en_all_o
);

  logic [NCH-1:0] ch_ok;
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      if (mdm_chg_i[c]) begin
        pend_d[c] = 1'b1;
      end else if (msr_rd_i[c]) begin
        pend_d[c] = 1'b0;
      end else begin
        pend_d[c] = pend_q[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[c] <= 1'b0;
      end else begin
        pend_q[c] <= pend_d[c];
      end
    end

    assign ch_ok[c] = ~irq_i[c] & dnz_i[c] & en_i[c] & rx_s_i[c] & ~pend_q[c] &
                      ~|delta_i[c*NMDM +: NMDM];
  end

  assign entry_ok_o = (&ch_ok) & ~wake_now_i;
  assign en_all_o   = &en_i;

  // R8
  mdm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mdm_chg_i) |=> !entry_ok_o);

endmodule

// File: rtl/slp_fsm.sv
// Sleep state machine with oscillator start-up timing.
module slp_fsm
  import uart_slp_pkg::*;
#(
  parameter int STARTUP_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_ok_i,
  input  logic       en_all_i,
  input  logic       wake_async_i,
  input  logic       wake_wr_i,
  input  logic       strap_i,
  output slp_state_e state_o,
  output logic       osc_en_o,
  output logic       bus_iso_o,
  output logic       clk_valid_o
);

  localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYC - 1);

  slp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_AWAKE: begin
        if (entry_ok_i) begin
          state_d = strap_i ? ST_PSAVE : ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (!en_all_i || wake_async_i || wake_wr_i) begin
          state_d = ST_WAKING;
        end else if (strap_i) begin
          state_d = ST_PSAVE;
        end
      end
      ST_PSAVE: begin
        if (!en_all_i || wake_async_i) begin
          state_d = ST_WAKING;
        end else if (!strap_i) begin
          state_d = ST_SLEEP;
        end
      end
      ST_WAKING: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_AWAKE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o     = state_q;
  assign osc_en_o    = (state_q == ST_AWAKE) || (state_q == ST_WAKING);
  assign bus_iso_o   = (state_q == ST_PSAVE);
  assign clk_valid_o = (state_q == ST_AWAKE);

  // R9
  en_clear_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SLEEP || state_q == ST_PSAVE) && !en_all_i) |=> state_q == ST_WAKING);

  // R11
  psave_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PSAVE && wake_wr_i && !wake_async_i && en_all_i && strap_i)
      |=> state_q == ST_PSAVE);

  // R6
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_valid_o) |-> $past(state_q == ST_WAKING));

  // R10
  iso_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_iso_o |-> !osc_en_o);

endmodule

// File: rtl/uart_sleep_ctrl.sv
// Top level: sleep / power-save controller for a two-channel UART.
module uart_sleep_ctrl
  import uart_slp_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int NMDM        = 4,
  parameter int STARTUP_CYC = 64
) (
  input  logic                clk_aon,
  input  logic                rst_aon_n,
  input  logic [NCH-1:0]      irq_pend_i,
  input  logic [NCH-1:0]      div_nz_i,
  input  logic [NCH-1:0]      slp_en_i,
  input  logic [NCH*NMDM-1:0] msr_delta_i,
  input  logic [NCH-1:0]      rx_i,
  input  logic [NCH*NMDM-1:0] modem_i,
  input  logic [NCH-1:0]      thr_wr_i,
  input  logic [NCH-1:0]      msr_rd_i,
  input  logic                psave_strap_i,
  output logic                osc_en_o,
  output logic                bus_iso_o,
  output logic                clk_valid_o,
  output logic [1:0]          state_o
);

  logic [NCH-1:0]      rx_s;
  logic [NCH*NMDM-1:0] mdm_s;
  logic                strap_s;
  logic                rx_fall;
  logic [NCH-1:0]      mdm_chg;
  logic                wake_async;
  logic                wake_wr;
  logic                entry_ok;
  logic                en_all;
  slp_state_e          state;

  slp_sync #(.W(NCH), .RST_BIT(1'b1)) u_rx_sync (
    .clk(clk_aon), .rst_n(rst_aon_n), .d_i(rx_i), .q_o(rx_s)
  );

  slp_sync #(.W(NCH*NMDM), .RST_BIT(1'b0)) u_mdm_sync (
    .clk(clk_aon), .rst_n(rst_aon_n), .d_i(modem_i), .q_o(mdm_s)
  );

  slp_sync #(.W(1), .RST_BIT(1'b0)) u_strap_sync (
    .clk(clk_aon), .rst_n(rst_aon_n), .d_i(psave_strap_i), .q_o(strap_s)
  );

  slp_wake_det #(.NCH(NCH), .NMDM(NMDM)) u_wake (
    .clk(clk_aon), .rst_n(rst_aon_n), .rx_s_i(rx_s), .mdm_s_i(mdm_s),
    .rx_fall_o(rx_fall), .mdm_chg_o(mdm_chg)
  );

  assign wake_async = rx_fall | (|mdm_chg);
  assign wake_wr    = |thr_wr_i;

  slp_entry_qual #(.NCH(NCH), .NMDM(NMDM)) u_qual (
    .clk(clk_aon), .rst_n(rst_aon_n), .irq_i(irq_pend_i), .dnz_i(div_nz_i),
    .en_i(slp_en_i), .delta_i(msr_delta_i), .rx_s_i(rx_s), .mdm_chg_i(mdm_chg),
    .msr_rd_i(msr_rd_i), .wake_now_i(wake_async | wake_wr),
    .entry_ok_o(entry_ok), .en_all_o(en_all)
  );

  slp_fsm #(.STARTUP_CYC(STARTUP_CYC)) u_fsm (
    .clk(clk_aon), .rst_n(rst_aon_n), .entry_ok_i(entry_ok), .en_all_i(en_all),
    .wake_async_i(wake_async), .wake_wr_i(wake_wr), .strap_i(strap_s),
    .state_o(state), .osc_en_o(osc_en_o), .bus_iso_o(bus_iso_o),
    .clk_valid_o(clk_valid_o)
  );

  assign state_o = state;

  // R3
  irq_hold_awake_chk: assert property (@(posedge clk_aon) disable iff (!rst_aon_n)
    (state == ST_AWAKE && |irq_pend_i) |=> state == ST_AWAKE);

endmodule

// File: tb/uart_sleep_ctrl_tb_top.sv
module uart_sleep_ctrl_tb_top;

  localparam int NCH = 2;
  localparam int SU  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] irq = '0, dnz = 2'b11, en = '0, rx = 2'b11, thr = '0, mrd = '0;
  logic [7:0] dlt = '0, mdm = '0;
  logic       strap = 1'b0;
  logic       osc_en, bus_iso, clk_valid;
  logic [1:0] state;

  int n_chk = 0;
  int n_err = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  uart_sleep_ctrl #(.NCH(NCH), .NMDM(4), .STARTUP_CYC(SU)) dut_i (
    .clk_aon(clk), .rst_aon_n(rst_n), .irq_pend_i(irq), .div_nz_i(dnz),
    .slp_en_i(en), .msr_delta_i(dlt), .rx_i(rx), .modem_i(mdm),
    .thr_wr_i(thr), .msr_rd_i(mrd), .psave_strap_i(strap),
    .osc_en_o(osc_en), .bus_iso_o(bus_iso), .clk_valid_o(clk_valid), .state_o(state)
  );

  // Behavioural reference model
  int         m_st, m_cnt;
  logic [1:0] r1, r2, r3, pend;
  logic [7:0] d1, d2, d3;
  logic       s1, s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; r1 = 2'b11; r2 = 2'b11; r3 = 2'b11;
      d1 = '0; d2 = '0; d3 = '0; s1 = 0; s2 = 0; pend = '0;
    end else begin
      bit wr, wm, ww, ok, enall;
      bit [1:0] mchg;
      wr = ((r3 & ~r2) != 0);
      for (int c = 0; c < 2; c++) mchg[c] = (((d3 ^ d2) >> (4 * c)) & 8'h0F) != 0;
      wm = wr || (mchg != 0);
      ww = (thr != 0);
      ok = 1;
      for (int c = 0; c < 2; c++)
        if (irq[c] || !dnz[c] || !en[c] || ((dlt >> (4 * c)) & 8'h0F) != 0 || !r2[c] || pend[c])
          ok = 0;
      if (wm || ww) ok = 0;
      enall = (en == 2'b11);
      case (m_st)
        0: if (ok) m_st = s2 ? 2 : 1;
        1: if (!enall || wm || ww) m_st = 3; else if (s2) m_st = 2;
        2: if (!enall || wm) m_st = 3; else if (!s2) m_st = 1;
        default: begin
          if (m_cnt == SU - 1) begin m_st = 0; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
      endcase
      for (int c = 0; c < 2; c++) begin
        if (mchg[c]) pend[c] = 1;
        else if (mrd[c]) pend[c] = 0;
      end
      r3 = r2; r2 = r1; r1 = rx;
      d3 = d2; d2 = d1; d1 = mdm;
      s2 = s1; s1 = strap;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] exp_v, act_v;
      exp_v = {2'(m_st), (m_st == 0 || m_st == 3), (m_st == 2), (m_st == 0)};
      act_v = {state, osc_en, bus_iso, clk_valid};
      n_chk++;
      if (act_v !== exp_v) begin
        n_err++;
        $display("FAIL %s model compare: actual=%b expected=%b", tag, act_v, exp_v);
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 state", state, 0); chk("R1 osc", osc_en, 1);
    chk("R1 valid", clk_valid, 1); chk("R1 iso", bus_iso, 0);
    rst_n = 1'b1;

    tag = "R3"; en = 2'b11; irq = 2'b01; cyc(10);
    chk("R3 irq blocks", state, 0);
    tag = "R2"; irq = 2'b00; cyc(6);
    chk("R2 asleep", state, 1); chk("R2 osc off", osc_en, 0); chk("R2 invalid", clk_valid, 0);

    tag = "R5"; thr = 2'b10; cyc(1); chk("R5 write wake", state, 3); thr = '0;
    tag = "R6"; cyc(4); chk("R6 still waking", state, 3); chk("R6 invalid", clk_valid, 0);
    cyc(1); chk("R6 awake", state, 0); chk("R6 valid", clk_valid, 1);
    tag = "R7"; cyc(1); chk("R7 re-entry", state, 1);

    tag = "R5"; rx = 2'b10; cyc(4); chk("R5 rx wake", state, 3);
    tag = "R4"; cyc(15); chk("R4 rx low blocks", state, 0);
    rx = 2'b11; cyc(8); chk("R4 rx idle sleeps", state, 1);

    dnz = 2'b01; thr = 2'b01; cyc(1); thr = '0; cyc(15);
    chk("R4 divisor zero blocks", state, 0);
    dnz = 2'b11; cyc(3); chk("R4 divisor back", state, 1);
    dlt = 8'h04; thr = 2'b01; cyc(1); thr = '0; cyc(15);
    chk("R4 delta blocks", state, 0);
    dlt = 8'h00; cyc(3); chk("R4 delta clear", state, 1);

    tag = "R8"; mdm = 8'h20; cyc(15); chk("R8 modem pending", state, 0);
    mrd = 2'b01; cyc(1); mrd = '0; cyc(5); chk("R8 other read", state, 0);
    mrd = 2'b10; cyc(1); mrd = '0; cyc(3); chk("R8 read releases", state, 1);

    tag = "R9"; en = 2'b01; cyc(1); chk("R9 forced wake", state, 3);
    cyc(15); chk("R9 stays awake", state, 0);
    en = 2'b11; cyc(3); chk("R9 re-enabled", state, 1);

    tag = "R10"; strap = 1'b1; cyc(4);
    chk("R10 psave", state, 2); chk("R10 iso", bus_iso, 1); chk("R10 osc off", osc_en, 0);

    tag = "R11"; thr = 2'b01; cyc(1); thr = '0; cyc(3); chk("R11 write ignored", state, 2);
    rx = 2'b01; cyc(4); chk("R11 rx wake", state, 3);
    rx = 2'b11; cyc(10); chk("R11 back to psave", state, 2);
    mdm = 8'h00; cyc(15); chk("R11 modem wake pending", state, 0);
    mrd = 2'b10; cyc(1); mrd = '0; cyc(3); chk("R11 psave after read", state, 2);

    tag = "R9"; en = 2'b10; cyc(1); chk("R9 psave forced wake", state, 3);
    cyc(10); en = 2'b11; cyc(3); chk("R9 psave re-enabled", state, 2);

    tag = "R12"; strap = 1'b0; cyc(4);
    chk("R12 back to sleep", state, 1); chk("R12 iso released", bus_iso, 0);

    cyc(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule